// File: doc/BRIEF.md
# Update-Snooping Cache Coherence Controller

This block keeps one small direct-mapped cache coherent with its peers on a shared snooping bus. Every line holds a single word plus a presence bit and one of three coherence states: exclusive-clean, shared or dirty. Copies held by other caches are never invalidated. A write to shared data is broadcast as an update, so that memory and every other holder refresh their copy. While a bus transaction runs, a wired-OR shared signal tells the requester whether any other cache holds the address. That answer picks the state a line enters after a fill or an update.

On the processor side the block takes a held read or write request and answers with a one-cycle ready pulse. Ready does not come until any bus work the request needs has finished. That work is a write-back of a dirty victim, a fill read, or an update broadcast, in that order. On the bus side the block also snoops transactions issued by other caches. It answers reads of lines it holds, flushing to memory when its copy is dirty. It applies update broadcasts to its copy. Arbitration and memory sit outside the block and appear as a grant/done handshake.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset every line is absent, `cpu_ready`, `bus_req` and `snp_shared` are low, and the first access to any address misses.
- R2: A read hit returns the stored word with a one-cycle `cpu_ready` pulse, raises no `bus_req` and leaves the line state unchanged.
- R3: A read miss issues a bus read (`bus_cmd` = 1). If `bus_shared_in` is low when it completes, the line is installed exclusive-clean with the word from `bus_rdata`.
- R4: A read miss that completes with `bus_shared_in` high installs the line as shared, so a later write hit to it broadcasts an update.
- R5: A write hit on a dirty line changes only the cached word, with no bus traffic, and the line stays dirty.
- R6: A write hit on an exclusive-clean line stores the word with no bus traffic and makes the line dirty.
- R7: A write hit on a shared line issues an update (`bus_cmd` = 2) carrying the address and new word. The line stays shared if `bus_shared_in` is high at completion and becomes exclusive-clean otherwise.
- R8: A write miss whose bus read sees `bus_shared_in` high installs the line as shared and then broadcasts the new word with an update command.
- R9: A write miss whose bus read sees `bus_shared_in` low keeps the new word in place of the fetched word, installs the line dirty, and issues no update.
- R10: A miss that replaces a dirty line first issues a write-back (`bus_cmd` = 3) with the victim's address and word, then the fill. A clean or shared victim is dropped with no write-back.
- R11: A snooped bus read (`snp_cmd` = 1) that hits raises `snp_shared` and drives the word on `snp_rdata` in the same cycle. It raises `snp_flush` only when the line is dirty, and the line becomes shared.
- R12: A snooped update (`snp_cmd` = 2) that hits overwrites the word with `snp_wdata`, raises `snp_shared` and makes the line shared. Snoops that miss, and snooped write-backs (`snp_cmd` = 3), leave `snp_shared` low and the line untouched.
- R13: `cpu_ready` rises only after the bus transaction in progress has completed (`bus_gnt` and `bus_done` high in the same cycle). Until then `bus_req`, `bus_cmd` and `bus_addr` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address; low log2(LINES) bits select the line |
| cpu_wdata | input | DW | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction pending |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Transaction complete (with `bus_gnt`) |
| bus_cmd | output | 2 | 1 read, 2 update, 3 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Word for update or write-back |
| bus_rdata | input | DW | Fill word returned by peers or memory |
| bus_shared_in | input | 1 | Wired-OR shared signal sampled at completion |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_wdata | input | DW | Snooped update word |
| snp_shared | output | 1 | This cache holds the snooped address |
| snp_rdata | output | DW | Word supplied for a snooped read |
| snp_flush | output | 1 | Memory must capture `snp_rdata` (dirty supply) |

## Verification
The bench uses the default parameters: 8-bit addresses, 16-bit words and four lines. With four lines, a handful of addresses that differ only above bit 1 collide on one index. That lets every eviction path, dirty or clean, be reached in a few dozen operations. Each of the three states is driven into every transition with both answers on the shared signal. A delayed grant exposes the ready timing, and snoops are aimed at dirty, clean and absent lines.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;
   typedef enum logic [1:0] {
      LS_EXCL  = 2'd0,
      LS_SHRD  = 2'd1,
      LS_DIRTY = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      BC_IDLE   = 2'd0,
      BC_READ   = 2'd1,
      BC_UPDATE = 2'd2,
      BC_WBACK  = 2'd3
   } bus_cmd_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import upd_coh_pkg::*;
#(
   parameter int LINES = 4,
   parameter int IW    = 2,
   parameter int TAG_W = 6,
   parameter int DW    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    a_idx,
   output logic             a_vld,
   output logic [TAG_W-1:0] a_tag,
   output logic [DW-1:0]    a_data,
   output line_st_e         a_st,
   input  logic [IW-1:0]    b_idx,
   output logic             b_vld,
   output logic [TAG_W-1:0] b_tag,
   output logic [DW-1:0]    b_data,
   output line_st_e         b_st,
   input  logic             w_en,
   input  logic [IW-1:0]    w_idx,
   input  logic [TAG_W-1:0] w_tag,
   input  logic [DW-1:0]    w_data,
   input  line_st_e         w_st
);
   logic             vld_q [LINES];
   logic [TAG_W-1:0] tag_q [LINES];
   logic [DW-1:0]    dat_q [LINES];
   line_st_e         st_q  [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            vld_q[i] <= 1'b0;
            tag_q[i] <= '0;
            dat_q[i] <= '0;
            st_q[i]  <= LS_EXCL;
         end
      end else if (w_en) begin
         vld_q[w_idx] <= 1'b1;
         tag_q[w_idx] <= w_tag;
         dat_q[w_idx] <= w_data;
         st_q[w_idx]  <= w_st;
      end
   end

   assign a_vld  = vld_q[a_idx];
   assign a_tag  = tag_q[a_idx];
   assign a_data = dat_q[a_idx];
   assign a_st   = st_q[a_idx];
   assign b_vld  = vld_q[b_idx];
   assign b_tag  = tag_q[b_idx];
   assign b_data = dat_q[b_idx];
   assign b_st   = st_q[b_idx];
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
   import upd_coh_pkg::*;
#(
   parameter int TAG_W = 6,
   parameter int DW    = 16
) (
   input  logic             s_valid,
   input  logic [1:0]       s_cmd,
   input  logic [TAG_W-1:0] s_tag,
   input  logic [DW-1:0]    s_data,
   input  logic             l_vld,
   input  logic [TAG_W-1:0] l_tag,
   input  logic [DW-1:0]    l_data,
   input  line_st_e         l_st,
   output logic             shared_o,
   output logic [DW-1:0]    data_o,
   output logic             flush_o,
   output logic             upd_en,
   output logic [DW-1:0]    upd_data,
   output line_st_e         upd_st
);
   logic hit, is_rd, is_up;

   always_comb begin
      hit      = s_valid && l_vld && (l_tag == s_tag);
      is_rd    = (s_cmd == BC_READ);
      is_up    = (s_cmd == BC_UPDATE);
      shared_o = hit && (is_rd || is_up);
      data_o   = (hit && is_rd) ? l_data : '0;
      flush_o  = hit && is_rd && (l_st == LS_DIRTY);
      upd_en   = shared_o;
      upd_data = is_up ? s_data : l_data;
      upd_st   = LS_SHRD;
   end
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
   import upd_coh_pkg::*;
#(
   parameter int AW    = 8,
   parameter int IW    = 2,
   parameter int TAG_W = 6,
   parameter int DW    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic [AW-1:0]    cpu_addr,
   input  logic [DW-1:0]    cpu_wdata,
   output logic             cpu_ready,
   output logic [DW-1:0]    cpu_rdata,
   input  logic             l_vld,
   input  logic [TAG_W-1:0] l_tag,
   input  logic [DW-1:0]    l_data,
   input  line_st_e         l_st,
   output logic             bus_req,
   output bus_cmd_e         bus_cmd,
   output logic [AW-1:0]    bus_addr,
   output logic [DW-1:0]    bus_wdata,
   input  logic             bus_gnt,
   input  logic             bus_done,
   input  logic             bus_shared,
   input  logic [DW-1:0]    bus_rdata,
   output logic             w_en,
   output logic [IW-1:0]    w_idx,
   output logic [TAG_W-1:0] w_tag,
   output logic [DW-1:0]    w_data,
   output line_st_e         w_st
);
   typedef enum logic [2:0] {F_IDLE, F_WBACK, F_FILL, F_UPD, F_RESP} fsm_e;

   fsm_e             st_q, st_d;
   logic [DW-1:0]    rdat_q, rdat_d;
   logic [IW-1:0]    idx;
   logic [TAG_W-1:0] tag;
   logic             hit, xfer;

   assign idx  = cpu_addr[IW-1:0];
   assign tag  = cpu_addr[AW-1:IW];
   assign hit  = l_vld && (l_tag == tag);
   assign xfer = bus_gnt && bus_done;

   always_comb begin
      st_d      = st_q;
      rdat_d    = rdat_q;
      w_en      = 1'b0;
      w_idx     = idx;
      w_tag     = tag;
      w_data    = cpu_wdata;
      w_st      = LS_DIRTY;
      bus_req   = 1'b0;
      bus_cmd   = BC_IDLE;
      bus_addr  = cpu_addr;
      bus_wdata = cpu_wdata;
      case (st_q)
         F_IDLE: begin
            if (cpu_req) begin
               if (hit) begin
                  if (!cpu_we) begin
                     rdat_d = l_data;
                     st_d   = F_RESP;
                  end else if (l_st == LS_SHRD) begin
                     st_d = F_UPD;
                  end else begin
                     w_en = 1'b1;
                     st_d = F_RESP;
                  end
               end else if (l_vld && (l_st == LS_DIRTY)) begin
                  st_d = F_WBACK;
               end else begin
                  st_d = F_FILL;
               end
            end
         end
         F_WBACK: begin
            bus_req   = 1'b1;
            bus_cmd   = BC_WBACK;
            bus_addr  = {l_tag, idx};
            bus_wdata = l_data;
            if (xfer) st_d = F_FILL;
         end
         F_FILL: begin
            bus_req   = 1'b1;
            bus_cmd   = BC_READ;
            bus_wdata = '0;
            if (xfer) begin
               w_en = 1'b1;
               if (!cpu_we) begin
                  w_data = bus_rdata;
                  w_st   = bus_shared ? LS_SHRD : LS_EXCL;
                  rdat_d = bus_rdata;
                  st_d   = F_RESP;
               end else if (bus_shared) begin
                  w_st = LS_SHRD;
                  st_d = F_UPD;
               end else begin
                  w_st = LS_DIRTY;
                  st_d = F_RESP;
               end
            end
         end
         F_UPD: begin
            bus_req = 1'b1;
            bus_cmd = BC_UPDATE;
            if (xfer) begin
               w_en = 1'b1;
               w_st = bus_shared ? LS_SHRD : LS_EXCL;
               st_d = F_RESP;
            end
         end
         F_RESP:  st_d = F_IDLE;
         default: st_d = F_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= F_IDLE;
         rdat_q <= '0;
      end else begin
         st_q   <= st_d;
         rdat_q <= rdat_d;
      end
   end

   assign cpu_ready = (st_q == F_RESP);
   assign cpu_rdata = rdat_q;
endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
   import upd_coh_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int LINES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ready,
   output logic [DW-1:0] cpu_rdata,
   output logic          bus_req,
   input  logic          bus_gnt,
   input  logic          bus_done,
   output logic [1:0]    bus_cmd,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_shared_in,
   input  logic          snp_valid,
   input  logic [1:0]    snp_cmd,
   input  logic [AW-1:0] snp_addr,
   input  logic [DW-1:0] snp_wdata,
   output logic          snp_shared,
   output logic [DW-1:0] snp_rdata,
   output logic          snp_flush
);
   localparam int IW    = (LINES > 1) ? $clog2(LINES) : 1;
   localparam int TAG_W = AW - IW;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("upd_coh_ctrl: LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_aw
      $error("upd_coh_ctrl: AW must exceed log2(LINES)");
   end
   if (DW < 1) begin : g_bad_dw
      $error("upd_coh_ctrl: DW must be positive");
   end

   logic             a_vld, b_vld;
   logic [TAG_W-1:0] a_tag, b_tag;
   logic [DW-1:0]    a_data, b_data;
   line_st_e         a_st, b_st;

   logic             f_wen;
   logic [IW-1:0]    f_widx;
   logic [TAG_W-1:0] f_wtag;
   logic [DW-1:0]    f_wdata;
   line_st_e         f_wst;
   bus_cmd_e         f_cmd;

   logic             s_upd;
   logic [DW-1:0]    s_data;
   line_st_e         s_st;

   logic             w_en;
   logic [IW-1:0]    w_idx;
   logic [TAG_W-1:0] w_tag;
   logic [DW-1:0]    w_data;
   line_st_e         w_st;

   coh_line_store #(.LINES(LINES), .IW(IW), .TAG_W(TAG_W), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_idx(cpu_addr[IW-1:0]), .a_vld(a_vld), .a_tag(a_tag), .a_data(a_data), .a_st(a_st),
      .b_idx(snp_addr[IW-1:0]), .b_vld(b_vld), .b_tag(b_tag), .b_data(b_data), .b_st(b_st),
      .w_en(w_en), .w_idx(w_idx), .w_tag(w_tag), .w_data(w_data), .w_st(w_st)
   );

   coh_req_fsm #(.AW(AW), .IW(IW), .TAG_W(TAG_W), .DW(DW)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .l_vld(a_vld), .l_tag(a_tag), .l_data(a_data), .l_st(a_st),
      .bus_req(bus_req), .bus_cmd(f_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_shared(bus_shared_in), .bus_rdata(bus_rdata),
      .w_en(f_wen), .w_idx(f_widx), .w_tag(f_wtag), .w_data(f_wdata), .w_st(f_wst)
   );

   coh_snoop_unit #(.TAG_W(TAG_W), .DW(DW)) u_snoop (
      .s_valid(snp_valid), .s_cmd(snp_cmd), .s_tag(snp_addr[AW-1:IW]), .s_data(snp_wdata),
      .l_vld(b_vld), .l_tag(b_tag), .l_data(b_data), .l_st(b_st),
      .shared_o(snp_shared), .data_o(snp_rdata), .flush_o(snp_flush),
      .upd_en(s_upd), .upd_data(s_data), .upd_st(s_st)
   );

   assign bus_cmd = f_cmd;

   always_comb begin
      if (s_upd) begin
         w_en   = 1'b1;
         w_idx  = snp_addr[IW-1:0];
         w_tag  = snp_addr[AW-1:IW];
         w_data = s_data;
         w_st   = s_st;
      end else begin
         w_en   = f_wen;
         w_idx  = f_widx;
         w_tag  = f_wtag;
         w_data = f_wdata;
         w_st   = f_wst;
      end
   end
endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_req,
   input logic          cpu_ready,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic          bus_done,
   input logic [1:0]    bus_cmd,
   input logic [AW-1:0] bus_addr,
   input logic          snp_valid,
   input logic [1:0]    snp_cmd,
   input logic          snp_shared,
   input logic          snp_flush
);
   AST_RDY_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && $past(bus_req)) |-> $past(bus_gnt && bus_done)); // R13

   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !(bus_gnt && bus_done)) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr))); // R13

   AST_RDY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> $past(cpu_req)); // R13

   AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready); // R2

   AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_cmd != 2'd0)); // R3

   AST_FLUSH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> (snp_shared && snp_cmd == 2'd1)); // R11

   AST_SHARED_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared |-> (snp_valid && snp_cmd != 2'd3)); // R12
endmodule

bind upd_coh_ctrl coh_ctrl_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
   .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_done(bus_done),
   .bus_cmd(bus_cmd), .bus_addr(bus_addr), .snp_valid(snp_valid),
   .snp_cmd(snp_cmd), .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/sim_upd_coh_ctrl.sv
module sim_upd_coh_ctrl;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int LINES = 4;
   localparam logic [1:0] C_RD = 2'd1, C_UP = 2'd2, C_WB = 2'd3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_req = 0, cpu_we = 0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0, cpu_rdata, bus_wdata, snp_rdata;
   logic [DW-1:0] bus_rdata = '0, snp_wdata = '0;
   logic cpu_ready, bus_req, snp_shared, snp_flush;
   logic bus_gnt = 0, bus_done = 0, bus_shared_in = 0, snp_valid = 0;
   logic [1:0] bus_cmd, snp_cmd = '0;
   logic [AW-1:0] bus_addr, snp_addr = '0;

   int nchk = 0, nerr = 0, cyc = 0;

   always #10 clk = ~clk;

   upd_coh_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u0 (.*);

   typedef struct packed {
      logic          we;
      logic [7:0]    a;
      logic [15:0]   wd;
      logic          shr;
      logic [15:0]   fill;
      logic [5:0]    seq;
      logic [15:0]   bd;
      logic [15:0]   rd;
      logic          chk;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'h10, 16'h0000, 1'b0, 16'hA001, 6'h01, 16'h0000, 16'hA001, 1'b1, 4'd3},  // R3
      '{1'b0, 8'h10, 16'h0000, 1'b0, 16'h0000, 6'h00, 16'h0000, 16'hA001, 1'b1, 4'd2},  // R2
      '{1'b1, 8'h10, 16'hB002, 1'b0, 16'h0000, 6'h00, 16'h0000, 16'h0000, 1'b0, 4'd6},  // R6
      '{1'b1, 8'h10, 16'hB003, 1'b0, 16'h0000, 6'h00, 16'h0000, 16'h0000, 1'b0, 4'd5},  // R5
      '{1'b0, 8'h10, 16'h0000, 1'b0, 16'h0000, 6'h00, 16'h0000, 16'hB003, 1'b1, 4'd5},  // R5
      '{1'b0, 8'h20, 16'h0000, 1'b1, 16'hC004, 6'h0D, 16'hB003, 16'hC004, 1'b1, 4'd10}, // R10
      '{1'b1, 8'h20, 16'hD005, 1'b1, 16'h0000, 6'h02, 16'hD005, 16'h0000, 1'b0, 4'd4},  // R4
      '{1'b1, 8'h20, 16'hD006, 1'b0, 16'h0000, 6'h02, 16'hD006, 16'h0000, 1'b0, 4'd7},  // R7
      '{1'b1, 8'h20, 16'hD007, 1'b0, 16'h0000, 6'h00, 16'h0000, 16'h0000, 1'b0, 4'd7},  // R7
      '{1'b1, 8'h31, 16'hE008, 1'b0, 16'h1111, 6'h01, 16'h0000, 16'h0000, 1'b0, 4'd9},  // R9
      '{1'b0, 8'h31, 16'h0000, 1'b0, 16'h0000, 6'h00, 16'h0000, 16'hE008, 1'b1, 4'd9},  // R9
      '{1'b1, 8'h42, 16'hF009, 1'b1, 16'h2222, 6'h06, 16'hF009, 16'h0000, 1'b0, 4'd8},  // R8
      '{1'b0, 8'h42, 16'h0000, 1'b0, 16'h0000, 6'h00, 16'h0000, 16'hF009, 1'b1, 4'd8},  // R8
      '{1'b1, 8'h42, 16'hF00A, 1'b1, 16'h0000, 6'h02, 16'hF00A, 16'h0000, 1'b0, 4'd8},  // R8
      '{1'b0, 8'h52, 16'h0000, 1'b0, 16'h3333, 6'h01, 16'h0000, 16'h3333, 1'b1, 4'd10}, // R10
      '{1'b0, 8'h62, 16'h0000, 1'b0, 16'h4444, 6'h01, 16'h0000, 16'h4444, 1'b1, 4'd10}, // R10
      '{1'b0, 8'h71, 16'h0000, 1'b0, 16'h5555, 6'h0D, 16'hE008, 16'h5555, 1'b1, 4'd10}  // R10
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic shr, input logic [DW-1:0] fill, input int dly,
                        output logic [5:0] seq, output logic [DW-1:0] bd,
                        output logic [DW-1:0] rd, output int lat, output logic early);
      int wc;
      seq = '0; bd = '0; rd = '0; lat = -1; early = 1'b0; wc = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         bus_gnt = 1'b0; bus_done = 1'b0;
         if (cpu_ready) begin
            if (bus_req) early = 1'b1;
            rd = cpu_rdata; lat = c; cpu_req = 1'b0;
            break;
         end
         if (bus_req) begin
            if (wc < dly) wc++;
            else begin
               wc = 0;
               bus_gnt = 1'b1; bus_done = 1'b1;
               bus_shared_in = shr; bus_rdata = fill;
               seq = {seq[3:0], bus_cmd};
               if (bus_cmd != C_RD) bd = bus_wdata;
            end
         end
      end
   endtask

   task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic shr, output logic [DW-1:0] rd, output logic fl);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a; snp_wdata = d;
      #1;
      shr = snp_shared; rd = snp_rdata; fl = snp_flush;
      @(negedge clk);
      snp_valid = 1'b0; snp_cmd = '0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         nerr++; nchk++;
         $display("FAIL watchdog actual=%0d expected<100000", cyc);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [5:0] sq; logic [DW-1:0] bd, rd; int lat; logic early;
      logic shr, fl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", cpu_ready, 0);
      chk("R1 bus_req after reset", bus_req, 0);
      chk("R1 snp_shared after reset", snp_shared, 0);

      for (int i = 0; i < NV; i++) begin
         do_op(VEC[i].we, VEC[i].a, VEC[i].wd, VEC[i].shr, VEC[i].fill, 0, sq, bd, rd, lat, early);
         chk($sformatf("R%0d vec%0d bus sequence", VEC[i].req, i), sq, VEC[i].seq);
         chk($sformatf("R%0d vec%0d bus data", VEC[i].req, i), bd, VEC[i].bd);
         if (VEC[i].chk) chk($sformatf("R%0d vec%0d read data", VEC[i].req, i), rd, VEC[i].rd);
      end

      // R11: snooped read of dirty line supplies data and flushes
      snoop(C_RD, 8'h20, 16'h0, shr, rd, fl);
      chk("R11 dirty snoop shared", shr, 1);
      chk("R11 dirty snoop data", rd, 16'hD007);
      chk("R11 dirty snoop flush", fl, 1);
      do_op(1'b1, 8'h20, 16'hAAAA, 1'b0, 16'h0, 0, sq, bd, rd, lat, early);
      chk("R11 line now shared: update issued", sq, {4'h0, C_UP});
      chk("R11 update data", bd, 16'hAAAA);
      // R11: clean line supplies without flush
      snoop(C_RD, 8'h62, 16'h0, shr, rd, fl);
      chk("R11 clean snoop shared", shr, 1);
      chk("R11 clean snoop data", rd, 16'h4444);
      chk("R11 clean snoop flush", fl, 0);
      // R12: misses and write-backs ignored
      snoop(C_RD, 8'h30, 16'h0, shr, rd, fl);
      chk("R12 tag miss shared", shr, 0);
      snoop(C_UP, 8'h13, 16'h9999, shr, rd, fl);
      chk("R12 empty line shared", shr, 0);
      snoop(C_WB, 8'h20, 16'h1234, shr, rd, fl);
      chk("R12 write-back snoop shared", shr, 0);
      do_op(1'b0, 8'h20, 16'h0, 1'b0, 16'h0, 0, sq, bd, rd, lat, early);
      chk("R12 write-back snoop left word", rd, 16'hAAAA);
      chk("R12 write-back snoop left state", sq, 0);
      // R12: snooped update overwrites and shares
      snoop(C_UP, 8'h71, 16'h7777, shr, rd, fl);
      chk("R12 update snoop shared", shr, 1);
      chk("R12 update snoop flush", fl, 0);
      do_op(1'b0, 8'h71, 16'h0, 1'b0, 16'h0, 0, sq, bd, rd, lat, early);
      chk("R12 updated word", rd, 16'h7777);
      do_op(1'b1, 8'h71, 16'h8888, 1'b0, 16'h0, 0, sq, bd, rd, lat, early);
      chk("R12 line shared after update snoop", sq, {4'h0, C_UP});
      // R13: ready waits for a delayed grant
      do_op(1'b0, 8'h03, 16'h0, 1'b0, 16'h6060, 5, sq, bd, rd, lat, early);
      chk("R13 delayed fill latency", lat, 6);
      chk("R13 ready with request pending", early, 0);
      chk("R13 delayed fill data", rd, 16'h6060);
      do_op(1'b0, 8'h03, 16'h0, 1'b0, 16'h0, 0, sq, bd, rd, lat, early);
      chk("R2 hit latency", lat, 0);
      chk("R2 hit data", rd, 16'h6060);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule